// File: doc/BRIEF.md
# Out-of-Frame SPI Sensor Link

This block is an SPI master for a sensor that exchanges 32-bit frames and returns the answer to a request one chip-select frame later. A host issues single commands on a simple port: an 8-bit register address, 16 bits of write data, a write flag and a capture flag. The block builds the request word, appends a 3-bit CRC and shifts the word out most significant bit first in SPI mode 0.

A write is one frame. A read is two frames: the first carries the request, and the second carries all zeros while the reply shifts in. The reply's CRC and its two status bits are checked. The 16-bit payload is returned together with an error flag. Between frames chip select stays high for a parameterized number of system clocks. A busy/done pair keeps new commands out while a transaction runs.

Top module: `sensor_link`

## Requirements
- R1: After reset csN=1, sclk=0, mosi=0, busy=0, done=0, rdData=0 and rdError=0.
- R2: A command is taken in a cycle where cmdValid=1 and busy=0. busy is 1 from the next cycle until the cycle in which done is 1. cmdValid is ignored while busy=1.
- R3: The request word is laid out as follows: bits 31:30 = 00, bits 29:22 = cmdAddr, bit 21 = cmdWrite, bit 20 = cmdCapture, bit 19 = 0, bits 18:3 = cmdWdata on a write and zero on a read, bits 2:0 = CRC.
- R4: The CRC starts from 3'b101. For each bit b of word bits 31 down to 3, the next value is {c[1:0],b} XOR (c[2] ? 3'b011 : 3'b000), which is division by 0xB. A word is consistent when this result equals its bits 2:0.
- R5: The link runs SPI mode 0. sclk idles low, and each half period lasts CLK_DIV clocks. A frame has 32 rising edges, with the first one CLK_DIV clocks after csN falls. mosi changes only on falling edges and presents the word MSB first. miso is sampled on rising edges.
- R6: A frame ends on its 32nd falling sclk edge, when csN rises. csN then stays high for exactly CS_GAP clocks before the next frame or before done.
- R7: A write is a single frame, and done follows 64*CLK_DIV+CS_GAP cycles after acceptance. rdData and rdError keep their values.
- R8: A read runs two frames, and done follows 2*(64*CLK_DIV+CS_GAP) cycles after acceptance. The second frame sends 32 zero bits, and only the word received in it is used as the reply.
- R9: On a read, rdData is loaded with bits 19:4 of the reply when done is 1.
- R10: On a read, rdError is 1 when the reply's CRC is inconsistent (R4) or when reply bits 31 and 3 are both 1. Otherwise it is 0.
- R11: done is a single-cycle pulse, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdWrite | input | 1 | 1 = register write, 0 = register read |
| cmdCapture | input | 1 | Capture flag placed in the request |
| cmdAddr | input | 8 | Register address |
| cmdWdata | input | 16 | Write payload |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Payload of the last read reply |
| rdError | output | 1 | Last read reply failed its checks |
| sclk | output | 1 | SPI clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The hardest case to reach from the ports is a reply that belongs to the wrong frame: a design that uses the first frame's received word would look correct whenever both frames return the same data. The bench's sensor model therefore loads a distinctive decoy word into the first frame of every read and a separate reply into the second. Replies are built with a good CRC, a corrupted CRC, both status bits set, and only one status bit set. A command is also pushed in the middle of a read to show that it is ignored.

// File: rtl/sensor_link_pkg.sv
`timescale 1ns/1ps
package sensor_link_pkg;

  localparam int FRAME_BITS = 32;
  localparam logic [2:0] CRC_SEED = 3'b101;
  localparam logic [2:0] CRC_FOLD = 3'b011;  // low bits of 0xB

  typedef struct packed {
    logic loadReq;    // load request word from command port
    logic loadBlank;  // load all-zero word for the reply frame
    logic shiftOut;   // advance transmit word (falling sclk)
    logic sampleIn;   // take one miso bit (rising sclk)
    logic commit;     // latch read result
  } linkStrobeT;

  function automatic logic [2:0] crc3Of(input logic [FRAME_BITS-4:0] body);
    logic [2:0] c;
    c = CRC_SEED;
    for (int i = FRAME_BITS - 4; i >= 0; i--) begin
      c = {c[1:0], body[i]} ^ (c[2] ? CRC_FOLD : 3'b000);
    end
    return c;
  endfunction

endpackage

// File: rtl/sensor_link_ctrl.sv
`timescale 1ns/1ps
module sensor_link_ctrl
  import sensor_link_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  output linkStrobeT strobe,
  output logic       sclk,
  output logic       csN,
  output logic       busy,
  output logic       done
);

  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W  = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int HC_W   = $clog2(CS_GAP + 1) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} stateT;

  stateT            state;
  logic [DIV_W-1:0] divCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkQ, csnQ, doneQ, isRead, secondFrame;
  logic             tick, gapEnd;

  assign tick   = (state == ST_FRAME) && (divCnt == DIV_LAST);
  assign gapEnd = (state == ST_GAP) && (gapCnt == GAP_LAST);

  always_comb begin
    strobe           = '0;
    strobe.loadReq   = (state == ST_IDLE) && cmdValid;
    strobe.loadBlank = gapEnd && isRead && !secondFrame;
    strobe.sampleIn  = tick && !sclkQ;
    strobe.shiftOut  = tick && sclkQ && (bitCnt != BIT_LAST);
    strobe.commit    = gapEnd && isRead && secondFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      divCnt      <= '0;
      gapCnt      <= '0;
      bitCnt      <= '0;
      sclkQ       <= 1'b0;
      csnQ        <= 1'b1;
      doneQ       <= 1'b0;
      isRead      <= 1'b0;
      secondFrame <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state       <= ST_FRAME;
            csnQ        <= 1'b0;
            sclkQ       <= 1'b0;
            divCnt      <= '0;
            bitCnt      <= '0;
            isRead      <= !cmdWrite;
            secondFrame <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            divCnt <= '0;
            sclkQ  <= !sclkQ;
            if (sclkQ) begin
              if (bitCnt == BIT_LAST) begin
                state  <= ST_GAP;
                csnQ   <= 1'b1;
                gapCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapEnd) begin
            if (isRead && !secondFrame) begin
              state       <= ST_FRAME;
              csnQ        <= 1'b0;
              divCnt      <= '0;
              bitCnt      <= '0;
              secondFrame <= 1'b1;
            end else begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign csN  = csnQ;
  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // Cycles spent with chip select high, saturating.
  logic [HC_W-1:0] highCnt;
  always_ff @(posedge clk) begin
    if (!rstN)     highCnt <= '1;
    else if (csnQ) highCnt <= (highCnt == '1) ? highCnt : highCnt + 1'b1;
    else           highCnt <= '0;
  end

  p_gap_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csnQ) |-> (highCnt >= HC_W'(CS_GAP)));

  p_sclk_parked_r5: assert property (@(posedge clk) disable iff (!rstN)
    csnQ |-> !sclkQ);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  p_start_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

endmodule

// File: rtl/sensor_link_dp.sv
`timescale 1ns/1ps
module sensor_link_dp
  import sensor_link_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  linkStrobeT  strobe,
  input  logic        cmdWrite,
  input  logic        cmdCapture,
  input  logic [7:0]  cmdAddr,
  input  logic [15:0] cmdWdata,
  input  logic        miso,
  output logic        mosi,
  output logic [15:0] rdData,
  output logic        rdError
);

  logic [FRAME_BITS-1:0] txSh, rxSh, reqWord;
  logic                  rxBad;

  always_comb begin
    reqWord        = '0;
    reqWord[29:22] = cmdAddr;
    reqWord[21]    = cmdWrite;
    reqWord[20]    = cmdCapture;
    reqWord[18:3]  = cmdWrite ? cmdWdata : 16'h0000;
    reqWord[2:0]   = crc3Of(reqWord[FRAME_BITS-1:3]);
  end

  assign rxBad = (crc3Of(rxSh[FRAME_BITS-1:3]) != rxSh[2:0]) || (rxSh[31] && rxSh[3]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      rdData  <= '0;
      rdError <= 1'b0;
    end else begin
      if (strobe.loadReq)        txSh <= reqWord;
      else if (strobe.loadBlank) txSh <= '0;
      else if (strobe.shiftOut)  txSh <= {txSh[FRAME_BITS-2:0], 1'b0};
      if (strobe.sampleIn)       rxSh <= {rxSh[FRAME_BITS-2:0], miso};
      if (strobe.commit) begin
        rdData  <= rxSh[19:4];
        rdError <= rxBad;
      end
    end
  end

  assign mosi = txSh[FRAME_BITS-1];

  p_status_pair_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxSh[31] && rxSh[3]) |=> rdError);

  p_result_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.commit) |-> $stable(rdData));

endmodule

// File: rtl/sensor_link.sv
`timescale 1ns/1ps
module sensor_link
  import sensor_link_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 150
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic        cmdCapture,
  input  logic [7:0]  cmdAddr,
  input  logic [15:0] cmdWdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        rdError,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);

  linkStrobeT strobe;

  sensor_link_ctrl #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .strobe(strobe), .sclk(sclk), .csN(csN), .busy(busy), .done(done)
  );

  sensor_link_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWrite(cmdWrite),
    .cmdCapture(cmdCapture), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .miso(miso), .mosi(mosi), .rdData(rdData), .rdError(rdError)
  );

  p_mosi_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$fell(sclk)) |-> $stable(mosi));

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && csN));

endmodule

// File: tb/test_sensor_link.sv
`timescale 1ns/1ps
module test_sensor_link;

  localparam int DIV = 4;
  localparam int GAP = 150;
  localparam int FR  = 64 * DIV + GAP;

  logic clk = 1'b0;
  logic rstN, cmdValid, cmdWrite, cmdCapture, miso;
  logic [7:0] cmdAddr;
  logic [15:0] cmdWdata;
  logic busy, done, rdError, sclk, csN, mosi;
  logic [15:0] rdData;

  always #2.5 clk = ~clk;

  sensor_link #(.CLK_DIV(DIV), .CS_GAP(GAP)) i_sensor_link (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCapture(cmdCapture), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .busy(busy), .done(done), .rdData(rdData), .rdError(rdError),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  int checks = 0, errors = 0;
  bit chkOn = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] crcOf(input logic [31:0] w);
    logic [3:0] c = 4'h5;
    for (int i = 31; i >= 3; i--) begin
      c = {c[2:0], w[i]};
      if (c[3]) c = c ^ 4'hB;
    end
    return c[2:0];
  endfunction

  function automatic logic [31:0] reqWord(input bit w, input bit cap,
                                          input logic [7:0] a, input logic [15:0] d);
    logic [31:0] r = '0;
    r[29:22] = a; r[21] = w; r[20] = cap;
    if (w) r[18:3] = d;
    r[2:0] = crcOf(r);
    return r;
  endfunction

  function automatic logic [31:0] replyWord(input logic [15:0] d, input bit s31, input bit s3);
    logic [31:0] r = '0;
    r[31] = s31; r[19:4] = d; r[3] = s3;
    r[2:0] = crcOf(r);
    return r;
  endfunction

  // Sensor model: answers from a queue, records what it receives.
  logic [31:0] replyQ[$];
  logic [31:0] mosiQ[$];
  logic [31:0] slvTx = '0, slvRx = '0;

  always @(negedge csN) begin
    slvTx = (replyQ.size() > 0) ? replyQ.pop_front() : 32'h0;
    miso = slvTx[31];
  end
  always @(negedge sclk) begin
    slvTx = slvTx << 1;
    miso = slvTx[31];
  end
  always @(posedge sclk) slvRx = {slvRx[30:0], mosi};
  always @(posedge csN) mosiQ.push_back(slvRx);

  // Behavioural cycle model.
  int t = 0, mFrames = 0;
  bit mAct = 0, mDone = 0, mRead = 0, mErr = 0, pendErr = 0;
  logic [15:0] mData = '0, pendData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mDone = 0; mData = '0; mErr = 0;
    end else begin
      mDone = 0;
      if (mAct) begin
        t++;
        if (t == mFrames * FR) begin
          mAct = 0; mDone = 1;
          if (mRead) begin mData = pendData; mErr = pendErr; end
        end
      end else if (cmdValid) begin
        mAct = 1; t = 0; mRead = !cmdWrite; mFrames = cmdWrite ? 1 : 2;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && chkOn) begin
      bit expCs, expSclk;
      int u;
      expCs = 1; expSclk = 0;
      if (mAct) begin
        u = t % FR;
        if (u < 64 * DIV) begin expCs = 0; expSclk = ((u / DIV) % 2) == 1; end
      end
      check(csN == expCs, "R6", "csN", 32'(csN), 32'(expCs));
      check(sclk == expSclk, "R5", "sclk", 32'(sclk), 32'(expSclk));
      check(busy == mAct, "R2", "busy", 32'(busy), 32'(mAct));
      check(done == mDone, "R11", "done", 32'(done), 32'(mDone));
      check(rdData == mData, "R9 R7", "rdData", 32'(rdData), 32'(mData));
      check(rdError == mErr, "R10", "rdError", 32'(rdError), 32'(mErr));
    end
  end

  task automatic issue(input bit w, input bit cap, input logic [7:0] a,
                       input logic [15:0] d, input bit poke);
    @(negedge clk);
    cmdValid = 1; cmdWrite = w; cmdCapture = cap; cmdAddr = a; cmdWdata = d;
    @(negedge clk);
    cmdValid = 0;
    if (poke) begin
      repeat (100) @(negedge clk);
      cmdValid = 1; cmdWrite = 1; cmdAddr = 8'h77; cmdWdata = 16'h1234;
      @(negedge clk);
      cmdValid = 0; cmdWrite = w; cmdAddr = a; cmdWdata = d;
    end
    while (!done) @(negedge clk);
    check(mosiQ.size() == (w ? 1 : 2), "R8", "frame count", 32'(mosiQ.size()), w ? 32'd1 : 32'd2);
    if (mosiQ.size() > 0)
      check(mosiQ[0] == reqWord(w, cap, a, d), "R3 R4", "request word", mosiQ[0], reqWord(w, cap, a, d));
    if (!w && mosiQ.size() > 1)
      check(mosiQ[1] == 32'h0, "R8", "reply-frame mosi", mosiQ[1], 32'h0);
    mosiQ.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    replyQ.push_back(32'hFFFF_FFFF);
    issue(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic doRead(input logic [7:0] a, input bit cap, input logic [31:0] r, input bit poke);
    replyQ.push_back(replyWord(16'hBAD0, 1'b0, 1'b0));  // decoy in request frame
    replyQ.push_back(r);
    pendData = r[19:4];
    pendErr  = (crcOf(r) != r[2:0]) || (r[31] && r[3]);
    issue(1'b0, cap, a, 16'h0, poke);
  endtask

  initial begin
    rstN = 0; cmdValid = 0; cmdWrite = 0; cmdCapture = 0; cmdAddr = '0; cmdWdata = '0; miso = 0;
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R1", "reset csN", 32'(csN), 32'd1);
    check(sclk == 1'b0 && mosi == 1'b0, "R1", "reset sclk/mosi", {sclk, mosi}, 32'd0);
    check(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 32'd0);
    check(rdData == 16'h0 && rdError == 1'b0, "R1", "reset result", {rdError, rdData}, 32'd0);
    rstN = 1;
    @(negedge clk);
    mosiQ.delete();
    chkOn = 1;
    doWrite(8'h2F, 16'h00B6);                                // R7, R3
    doRead(8'h11, 1'b0, replyWord(16'h1234, 1'b0, 1'b0), 0); // R9, R8
    doWrite(8'h0A, 16'h005F);                                // R7 rdData held
    doRead(8'h14, 1'b1, replyWord(16'h8001, 1'b1, 1'b0), 0); // R10 one status bit
    doRead(8'h15, 1'b0, replyWord(16'h7FFE, 1'b1, 1'b1), 0); // R10 both status bits
    doRead(8'h16, 1'b0, replyWord(16'hC3A5, 1'b0, 1'b0) ^ 32'h1, 0); // R10 bad CRC
    doRead(8'h10, 1'b1, replyWord(16'h00FF, 1'b0, 1'b1), 1); // R2 poke ignored
    doRead(8'hFF, 1'b1, replyWord(16'hFFFF, 1'b0, 1'b0), 0); // R3 address extremes
    doWrite(8'h00, 16'hFFFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule